// File: doc/BRIEF.md
# Dual-Clock Reload Timer Pair

This block holds two independent 8-bit reload timers. Each one counts on its own oscillator clock. Timer 0 runs on a high-frequency clock and timer 1 on a 32.768 kHz timekeeping clock. The processor reaches both timers on a third clock, the processor clock. It writes and reads each reload register there and receives overflow events there as one-cycle pulses for the interrupt logic.

Each counter counts up on every edge of its own clock. After it reaches its top value it loads the reload value instead of wrapping to zero. A timer therefore overflows every 256 minus reload counts.

A reload write is held in a processor-side shadow register. It is sent to the counting domain through a toggle request and acknowledge handshake, and the counter picks it up at its next overflow. Each overflow flips a toggle in the counting domain. The processor domain synchronizes that toggle and turns every change of it into a single-cycle pulse.

Top module: `dual_domain_reload_timer`

## Requirements
- R1: While `rst_cpu` is high, both reload registers read 0x00 and `ovf_evt` is 0. A counting-domain reset clears that timer's counter and its armed reload to zero. After all resets are released together, each timer's first overflow comes 256 of its own count clocks later.
- R2: A processor write stores `wr_data` in the reload register that `wr_sel` picks (0 = high-frequency timer, 1 = timekeeping timer). `rd_data` shows that value one processor cycle later whenever `rd_sel` names the same timer. The other timer's reload value stays as it was.
- R3: The counter counts up by one per count clock. From 0xFF it loads the reload value R, so overflows repeat every 256 − R count clocks.
- R4: A reload write leaves the count period already in progress unchanged. The new value is first used at the next overflow.
- R5: When several writes reach one timer in quick succession, the value written last ends up governing its period.
- R6: Each overflow gives exactly one pulse, one processor cycle wide, on `ovf_evt[0]` for the high-frequency timer or on `ovf_evt[1]` for the timekeeping timer. This holds as long as overflows are spaced further apart than the synchronizer latency.
- R7: The two timers are independent. Writes to one timer, and its overflows, leave the other timer's period and reload value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor clock; register access and event pulses |
| rst_cpu | input | 1 | Synchronous active-high reset, processor domain |
| clk_hf | input | 1 | High-frequency count clock for timer 0 |
| rst_hf | input | 1 | Synchronous active-high reset, timer 0 count domain |
| clk_lf | input | 1 | Timekeeping count clock for timer 1 |
| rst_lf | input | 1 | Synchronous active-high reset, timer 1 count domain |
| wr_en | input | 1 | Reload write strobe, one processor cycle |
| wr_sel | input | 1 | Timer selected by the write (0 or 1) |
| wr_data | input | CNT_W | Reload value to write |
| rd_sel | input | 1 | Timer whose reload value appears on rd_data |
| rd_data | output | CNT_W | Reload value of the selected timer |
| ovf_evt | output | 2 | One-cycle overflow pulses, bit per timer |

## Verification
The bench builds the block with its default parameters: 8-bit counters and two synchronizer stages. It runs the three clocks at unrelated periods of 8 ns, 14 ns and 62 ns. Because the counters are the full 8 bits, the 256-count period after reset and the zero-reload case are both reachable. Reload values up to 0xF0 bring 16-count periods within reach, where the handshake latency is a visible fraction of the period. The unrelated clock periods make each reload transfer and overflow pulse cross a real phase offset. Periods are measured as the time between processor-side pulses, which lets the bench separate an old period still in progress from a new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_COUNT      = 2;
    localparam int TMR_DEF_WIDTH  = 8;
    localparam int TMR_DEF_STAGES = 2;

    typedef enum logic {
        TMR_HF = 1'b0,
        TMR_LF = 1'b1
    } tmr_id_e;

    // Handshake flags that one timer lane exchanges across domains.
    typedef struct packed {
        logic req;
        logic ack;
        logic ovf;
    } tmr_tgl_t;

    // A toggle line signals an event whenever its synced value differs
    // from the value seen on the previous cycle.
    function automatic logic tgl_event(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

endpackage

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_reload_src.sv
module tmr_reload_src #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ack_tgl_a,
    output logic [W-1:0] rld_q,
    output logic [W-1:0] xfer_data,
    output logic         req_tgl
);
    logic ack_s;
    logic dirty;
    logic busy;

    tmr_bit_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_a),
        .q   (ack_s)
    );

    assign busy = tmr_pkg::tgl_event(req_tgl, ack_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q     <= '0;
            xfer_data <= '0;
            req_tgl   <= 1'b0;
            dirty     <= 1'b0;
        end else begin
            // Launch a transfer of the shadow value once the lane is idle.
            if (dirty && !busy) begin
                xfer_data <= rld_q;
                req_tgl   <= ~req_tgl;
                dirty     <= 1'b0;
            end
            // A write in the same cycle keeps the lane dirty for a resend.
            if (wr_en) begin
                rld_q <= wr_data;
                dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_tgl_a,
    input  logic [W-1:0] xfer_data,
    output logic         ack_tgl,
    output logic         ovf_tgl,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic         req_s;
    logic         req_d;
    logic [W-1:0] armed_rld;

    tmr_bit_sync #(.STAGES(STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl_a),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d     <= 1'b0;
            armed_rld <= '0;
            cnt_q     <= '0;
            ovf_tgl   <= 1'b0;
        end else begin
            req_d <= req_s;
            // The source holds xfer_data still while the request is open.
            if (tmr_pkg::tgl_event(req_s, req_d)) begin
                armed_rld <= xfer_data;
            end
            if (cnt_q == CNT_TOP) begin
                cnt_q   <= armed_rld;
                ovf_tgl <= ~ovf_tgl;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

    assign ack_tgl = req_d;
endmodule

// File: rtl/tmr_event_sink.sv
module tmr_event_sink #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ovf_tgl_a,
    output logic evt
);
    logic tgl_s;
    logic tgl_d;

    tmr_bit_sync #(.STAGES(STAGES)) u_ovf_sync (
        .clk (clk),
        .rst (rst),
        .d   (ovf_tgl_a),
        .q   (tgl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_d <= 1'b0;
        end else begin
            tgl_d <= tgl_s;
        end
    end

    assign evt = tmr_pkg::tgl_event(tgl_s, tgl_d);
endmodule

// File: rtl/dual_domain_reload_timer.sv
module dual_domain_reload_timer #(
    parameter int CNT_W       = tmr_pkg::TMR_DEF_WIDTH,
    parameter int SYNC_STAGES = tmr_pkg::TMR_DEF_STAGES
) (
    input  logic             clk_cpu,
    input  logic             rst_cpu,
    input  logic             clk_hf,
    input  logic             rst_hf,
    input  logic             clk_lf,
    input  logic             rst_lf,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic [1:0]       ovf_evt
);
    import tmr_pkg::*;

    localparam int N = TMR_COUNT;

    logic [N-1:0]            cnt_clk;
    logic [N-1:0]            cnt_rst;
    logic [N-1:0][CNT_W-1:0] rld_all;
    logic [N-1:0][CNT_W-1:0] xfer_all;
    logic [N-1:0][CNT_W-1:0] cnt_q_all;
    tmr_tgl_t [N-1:0]        tgl_all;
    logic [N-1:0]            ovf_tgl_all;

    assign cnt_clk = {clk_lf, clk_hf};
    assign cnt_rst = {rst_lf, rst_hf};

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic lane_wr;
        assign lane_wr = wr_en && (wr_sel == tmr_id_e'(i));

        tmr_reload_src #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_src (
            .clk       (clk_cpu),
            .rst       (rst_cpu),
            .wr_en     (lane_wr),
            .wr_data   (wr_data),
            .ack_tgl_a (tgl_all[i].ack),
            .rld_q     (rld_all[i]),
            .xfer_data (xfer_all[i]),
            .req_tgl   (tgl_all[i].req)
        );

        tmr_count_core #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_core (
            .clk       (cnt_clk[i]),
            .rst       (cnt_rst[i]),
            .req_tgl_a (tgl_all[i].req),
            .xfer_data (xfer_all[i]),
            .ack_tgl   (tgl_all[i].ack),
            .ovf_tgl   (tgl_all[i].ovf),
            .cnt_q     (cnt_q_all[i])
        );

        tmr_event_sink #(.STAGES(SYNC_STAGES)) u_sink (
            .clk       (clk_cpu),
            .rst       (rst_cpu),
            .ovf_tgl_a (tgl_all[i].ovf),
            .evt       (ovf_evt[i])
        );

        assign ovf_tgl_all[i] = tgl_all[i].ovf;
    end

    assign rd_data = rld_all[rd_sel];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 8
) (
    input logic             clk_cpu,
    input logic             rst_cpu,
    input logic             clk_hf,
    input logic             rst_hf,
    input logic             clk_lf,
    input logic             rst_lf,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [W-1:0]     wr_data,
    input logic             rd_sel,
    input logic [W-1:0]     rd_data,
    input logic [1:0]       ovf_evt,
    input logic [1:0][W-1:0] cnt_q,
    input logic [1:0]       ovf_tgl
);
    // R1: reset leaves the processor side quiet and cleared.
    p_reset_quiet_r1: assert property (@(posedge clk_cpu)
        rst_cpu |=> (ovf_evt == 2'b00));

    p_reset_clear_r1: assert property (@(posedge clk_cpu)
        (rst_cpu && !wr_en) |=> (rd_data == '0));

    // R2: a write is visible on the read port one cycle later.
    p_readback_r2: assert property (@(posedge clk_cpu) disable iff (rst_cpu)
        wr_en |=> ((rd_sel != $past(wr_sel)) || (rd_data == $past(wr_data))));

    // R6: every overflow pulse lasts exactly one processor cycle.
    p_pulse_width_hf_r6: assert property (@(posedge clk_cpu) disable iff (rst_cpu)
        ovf_evt[0] |=> !ovf_evt[0]);

    p_pulse_width_lf_r6: assert property (@(posedge clk_cpu) disable iff (rst_cpu)
        ovf_evt[1] |=> !ovf_evt[1]);

    // R3: the overflow toggle only moves when the counter left its top value.
    p_wrap_from_top_hf_r3: assert property (@(posedge clk_hf) disable iff (rst_hf)
        !$stable(ovf_tgl[0]) |-> ($past(cnt_q[0]) == '1));

    p_wrap_from_top_lf_r3: assert property (@(posedge clk_lf) disable iff (rst_lf)
        !$stable(ovf_tgl[1]) |-> ($past(cnt_q[1]) == '1));
endmodule

bind dual_domain_reload_timer tmr_checker #(.W(CNT_W)) u_chk (
    .clk_cpu (clk_cpu),
    .rst_cpu (rst_cpu),
    .clk_hf  (clk_hf),
    .rst_hf  (rst_hf),
    .clk_lf  (clk_lf),
    .rst_lf  (rst_lf),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .ovf_evt (ovf_evt),
    .cnt_q   (cnt_q_all),
    .ovf_tgl (ovf_tgl_all)
);

// File: tb/sim_dual_domain_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_domain_reload_timer;
    localparam real T_CPU = 8.0;
    localparam real T_HF  = 14.0;
    localparam real T_LF  = 62.0;
    localparam real TOL   = 9.0;
    localparam int  NVEC  = 7;

    // {timer select, reload value, expected period in count clocks}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 9'd256},
        {1'b0, 8'h10, 9'd240},
        {1'b0, 8'hF0, 9'd16},
        {1'b0, 8'h7F, 9'd129},
        {1'b1, 8'h80, 9'd128},
        {1'b1, 8'hF0, 9'd16},
        {1'b1, 8'hC3, 9'd61}
    };

    logic       clk_cpu = 0, clk_hf = 0, clk_lf = 0;
    logic       rst_cpu = 1, rst_hf = 1, rst_lf = 1;
    logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [1:0] ovf_evt;

    int checks = 0;
    int failures = 0;
    logic [7:0] model_rld [2];

    always #4  clk_cpu = ~clk_cpu;
    always #7  clk_hf  = ~clk_hf;
    always #31 clk_lf  = ~clk_lf;

    dual_domain_reload_timer u0 (
        .clk_cpu (clk_cpu), .rst_cpu (rst_cpu),
        .clk_hf  (clk_hf),  .rst_hf  (rst_hf),
        .clk_lf  (clk_lf),  .rst_lf  (rst_lf),
        .wr_en   (wr_en),   .wr_sel  (wr_sel),
        .wr_data (wr_data), .rd_sel  (rd_sel),
        .rd_data (rd_data), .ovf_evt (ovf_evt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0.1f expected=%0.1f", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk_cpu);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk_cpu);
        wr_en = 0;
        model_rld[sel] = d;
    endtask

    task automatic read_check(input logic sel, input string req);
        rd_sel = sel;
        #1;
        check(rd_data == model_rld[sel], req, "reload readback",
              real'(rd_data), real'(model_rld[sel]));
    endtask

    // Waits for a pulse on one timer's event bit, then checks its width (R6).
    task automatic wait_pulse(input int sel, output realtime t);
        int n = 0;
        t = 0;
        forever begin
            @(negedge clk_cpu);
            if (ovf_evt[sel]) break;
            n++;
            if (n > 6000) begin
                check(0, "R6", "pulse timeout", 0.0, 1.0);
                return;
            end
        end
        t = $realtime;
        @(negedge clk_cpu);
        check(ovf_evt[sel] == 1'b0, "R6", "pulse one cycle wide",
              real'(ovf_evt[sel]), 0.0);
    endtask

    task automatic measure_period(input int sel, output real per);
        realtime t1, t2, t3;
        wait_pulse(sel, t1);
        wait_pulse(sel, t2);
        wait_pulse(sel, t3);
        per = t3 - t2;
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        realtime t_rel, ta, tb_, tc;
        real per, exp;
        model_rld[0] = 0;
        model_rld[1] = 0;

        repeat (40) @(negedge clk_cpu);
        // R1: reset state
        check(ovf_evt == 2'b00, "R1", "no events in reset", real'(ovf_evt), 0.0);
        read_check(1'b0, "R1");
        read_check(1'b1, "R1");
        @(negedge clk_cpu);
        rst_cpu = 0; rst_hf = 0; rst_lf = 0;
        t_rel = $realtime;

        // R1: first overflow 256 count clocks after release
        wait_pulse(0, ta);
        check((ta - t_rel >= 255*T_HF) && (ta - t_rel <= 256*T_HF + 40), "R1",
              "first high-frequency overflow time", ta - t_rel, 256*T_HF);
        wait_pulse(1, tb_);
        check((tb_ - t_rel >= 255*T_LF) && (tb_ - t_rel <= 256*T_LF + 40), "R1",
              "first timekeeping overflow time", tb_ - t_rel, 256*T_LF);

        // R2, R3: vector table of reloads and periods
        for (int i = 0; i < NVEC; i++) begin
            logic       sel;
            logic [7:0] rv;
            int         cnt;
            sel = VEC[i][17];
            rv  = VEC[i][16:9];
            cnt = int'(VEC[i][8:0]);
            cpu_write(sel, rv);
            read_check(sel, "R2");
            read_check(~sel, "R2");
            measure_period(int'(sel), per);
            exp = cnt * (sel ? T_LF : T_HF);
            check((per > exp - TOL) && (per < exp + TOL), "R3",
                  "overflow period", per, exp);
        end

        // R4: a write lands mid-period; that period keeps the old reload
        cpu_write(1'b0, 8'h00);
        measure_period(0, per);
        wait_pulse(0, ta);
        cpu_write(1'b0, 8'hE0);
        wait_pulse(0, tb_);
        wait_pulse(0, tc);
        check((tb_ - ta > 256*T_HF - TOL) && (tb_ - ta < 256*T_HF + TOL), "R4",
              "period in progress keeps old reload", tb_ - ta, 256*T_HF);
        check((tc - tb_ > 32*T_HF - TOL) && (tc - tb_ < 32*T_HF + TOL), "R4",
              "new reload used after next overflow", tc - tb_, 32*T_HF);

        // R5: back-to-back writes, last one wins
        @(negedge clk_cpu);
        wr_en = 1; wr_sel = 0; wr_data = 8'h40;
        @(negedge clk_cpu);
        wr_data = 8'hA0;
        @(negedge clk_cpu);
        wr_en = 0;
        model_rld[0] = 8'hA0;
        read_check(1'b0, "R5");
        measure_period(0, per);
        check((per > 96*T_HF - TOL) && (per < 96*T_HF + TOL), "R5",
              "last of back-to-back writes governs", per, 96*T_HF);

        // R7: writing the other timer leaves this one untouched
        cpu_write(1'b1, 8'h00);
        read_check(1'b0, "R7");
        measure_period(0, per);
        check((per > 96*T_HF - TOL) && (per < 96*T_HF + TOL), "R7",
              "high-frequency period independent of other timer", per, 96*T_HF);
        measure_period(1, per);
        check((per > 256*T_LF - TOL) && (per < 256*T_LF + TOL), "R7",
              "timekeeping period after its own write", per, 256*T_LF);

        // R1: processor reset clears the reload registers
        @(negedge clk_cpu);
        rst_cpu = 1;
        @(negedge clk_cpu);
        @(negedge clk_cpu);
        model_rld[0] = 0;
        model_rld[1] = 0;
        check(ovf_evt == 2'b00, "R1", "no events during reset", real'(ovf_evt), 0.0);
        read_check(1'b0, "R1");
        read_check(1'b1, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule